// File: doc/BRIEF.md
# Dynamic Priority Interrupt Arbiter

This block chooses a single winning interrupt line from a set of up to three banks of 32 lines. Each line carries four pieces of state: a pending bit, a mask bit, a class bit and a priority value. A class-select input asks for the winner among either the fast class or the normal class. The block returns the winner's global line number and a flag that tells whether any line qualified at all.

An interrupt controller instantiates this block beside its register file and its edge logic. The controller pulses a capture strobe when it wants a fresh decision. The selection is computed combinationally by a balanced comparison tree. It is stored on the clock edge at which the strobe is high, and it stays unchanged until the next strobe.

The bank count (1 to 3) and the priority width (5 or 6 bits) are parameters. Both are checked during elaboration.

Top module: `arb_top`

## Requirements
- R1: A line qualifies only when three conditions hold: its bit in `pend` is 1, its bit in `mask` is 0, and its bit in `route` equals `sel_fast`. A `route` bit of 1 marks the fast class and 0 marks the normal class. A line that does not qualify never wins.
- R2: Among qualifying lines, the line with the numerically smallest priority wins. The value 0 is the most urgent.
- R3: When several qualifying lines share the smallest priority, the line with the largest global index wins.
- R4: Line k is bit k of `pend`, `mask` and `route`, and its priority is `prio_flat[k*PRIO_W +: PRIO_W]`. Line k is reported as index k, which equals 32 × bank + bit within the bank.
- R5: When no line qualifies, `win_idx` is 0 and `win_any` is 0.
- R6: `win_any` is 1 exactly when at least one line qualified at the capture edge.
- R7: The outputs take a new value only on a rising clock edge at which `capture` is 1. On any other edge they hold their value, whatever the other inputs do.
- R8: While `rst_n` is low, `win_idx` is 0 and `win_any` is 0.
- R9: Every bit of the priority field takes part in the comparison. With a 6-bit width, the value 31 beats the value 32.
- R10: A single set of line inputs gives independent fast and normal winners, chosen only by `sel_fast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture | input | 1 | Stores the current selection on this edge |
| sel_fast | input | 1 | Class requested: 1 fast, 0 normal |
| pend | input | NUM_BANKS*32 | Pending bit per line |
| mask | input | NUM_BANKS*32 | Mask bit per line (1 blocks the line) |
| route | input | NUM_BANKS*32 | Class bit per line |
| prio_flat | input | NUM_BANKS*32*PRIO_W | Packed priority fields, line 0 in the low bits |
| win_idx | output | 7 | Global index of the stored winner |
| win_any | output | 1 | 1 when the stored decision had a qualifying line |

## Verification
The hardest case to reach from the ports is a set of qualifying lines that tie at the best priority while sitting in different banks and in different halves of the tree. Only such a case shows whether the tie is resolved toward the higher index at every level of the tree. The stimulus forces this case in two ways. Directed patterns place tied lines across bank boundaries. Random patterns draw priorities from a range of only four values over dense pending vectors, which makes multi-way ties common. A bench-side linear scan supplies the expected winner for every pattern and for both classes.

// File: rtl/arb_pkg.sv
package arb_pkg;
   localparam int LINES_PER_BANK = 32;
   localparam int MAX_BANKS      = 3;
   localparam int MAX_PRIO_W     = 6;
   localparam int IDX_W          = $clog2(LINES_PER_BANK * MAX_BANKS);

   // One contender travelling up the comparison tree
   typedef struct packed {
      logic                  vld;
      logic [MAX_PRIO_W-1:0] prio;
      logic [IDX_W-1:0]      idx;
   } cand_t;

   // lo covers lower line numbers than hi; hi wins ties
   function automatic cand_t pick(input cand_t lo, input cand_t hi);
      if (hi.vld && (!lo.vld || (hi.prio <= lo.prio)))
         return hi;
      return lo;
   endfunction
endpackage

// File: rtl/arb_elig.sv
module arb_elig #(
   parameter int N = 96
) (
   input  logic         sel_fast,
   input  logic [N-1:0] pend,
   input  logic [N-1:0] mask,
   input  logic [N-1:0] route,
   output logic [N-1:0] elig
);
   logic [N-1:0] class_match;

   assign class_match = sel_fast ? route : ~route;
   assign elig        = pend & ~mask & class_match;
endmodule

// File: rtl/arb_leaf.sv
module arb_leaf
   import arb_pkg::*;
#(
   parameter int N      = 96,
   parameter int PRIO_W = 6,
   parameter int LEAVES = 128
) (
   input  logic [N-1:0]        elig,
   input  logic [N*PRIO_W-1:0] prio_flat,
   output cand_t               leaf [LEAVES]
);
   for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
      if (k < N) begin : g_real
         logic [MAX_PRIO_W-1:0] p_ext;
         if (PRIO_W == MAX_PRIO_W) begin : g_full
            assign p_ext = prio_flat[k*PRIO_W +: PRIO_W];
         end else begin : g_narrow
            assign p_ext = {{(MAX_PRIO_W-PRIO_W){1'b0}}, prio_flat[k*PRIO_W +: PRIO_W]};
         end
         assign leaf[k] = '{vld:  elig[k],
                            prio: p_ext,
                            idx:  elig[k] ? IDX_W'(k) : '0};
      end else begin : g_pad
         assign leaf[k] = '{vld: 1'b0, prio: '1, idx: '0};
      end
   end
endmodule

// File: rtl/arb_tree.sv
module arb_tree
   import arb_pkg::*;
#(
   parameter int LEAVES = 128
) (
   input  cand_t leaf [LEAVES],
   output cand_t root
);
   localparam int DEPTH = $clog2(LEAVES);

   for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
      localparam int W = LEAVES >> l;
      cand_t v [W];
      if (l == 0) begin : g_base
         for (genvar j = 0; j < W; j++) begin : g_cp
            assign v[j] = leaf[j];
         end
      end else begin : g_merge
         for (genvar j = 0; j < W; j++) begin : g_cmp
            assign v[j] = pick(g_lvl[l-1].v[2*j], g_lvl[l-1].v[2*j+1]);
         end
      end
   end

   assign root = g_lvl[DEPTH].v[0];
endmodule

// File: rtl/arb_top.sv
module arb_top
   import arb_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int PRIO_W    = 6
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      capture,
   input  logic                                      sel_fast,
   input  logic [NUM_BANKS*LINES_PER_BANK-1:0]        pend,
   input  logic [NUM_BANKS*LINES_PER_BANK-1:0]        mask,
   input  logic [NUM_BANKS*LINES_PER_BANK-1:0]        route,
   input  logic [NUM_BANKS*LINES_PER_BANK*PRIO_W-1:0] prio_flat,
   output logic [IDX_W-1:0]                           win_idx,
   output logic                                       win_any
);
   localparam int N      = NUM_BANKS * LINES_PER_BANK;
   localparam int LEAVES = 1 << $clog2(N);

   if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
      $error("arb_top: NUM_BANKS must lie in 1..3");
   end
   if (PRIO_W != 5 && PRIO_W != 6) begin : g_bad_prio
      $error("arb_top: PRIO_W must be 5 or 6");
   end

   logic [N-1:0] elig;
   cand_t        leaf [LEAVES];
   cand_t        root;

   arb_elig #(.N(N)) u_elig (
      .sel_fast (sel_fast),
      .pend     (pend),
      .mask     (mask),
      .route    (route),
      .elig     (elig)
   );

   arb_leaf #(.N(N), .PRIO_W(PRIO_W), .LEAVES(LEAVES)) u_leaf (
      .elig      (elig),
      .prio_flat (prio_flat),
      .leaf      (leaf)
   );

   arb_tree #(.LEAVES(LEAVES)) u_tree (
      .leaf (leaf),
      .root (root)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_idx <= '0;
         win_any <= 1'b0;
      end else if (capture) begin
         win_idx <= root.vld ? root.idx : '0;
         win_any <= root.vld;
      end
   end
endmodule

// File: rtl/arb_top_chk.sv
module arb_top_chk
   import arb_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int PRIO_W    = 6
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                capture,
   input logic                                sel_fast,
   input logic [NUM_BANKS*LINES_PER_BANK-1:0] pend,
   input logic [NUM_BANKS*LINES_PER_BANK-1:0] mask,
   input logic [NUM_BANKS*LINES_PER_BANK-1:0] route,
   input logic [IDX_W-1:0]                    win_idx,
   input logic                                win_any
);
   localparam int N    = NUM_BANKS * LINES_PER_BANK;
   localparam int SPAN = 1 << IDX_W;

   logic [SPAN-1:0] elig_q;
   logic [N-1:0]    elig_now;

   assign elig_now = pend & ~mask & (sel_fast ? route : ~route);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       elig_q <= '0;
      else if (capture) elig_q <= SPAN'(elig_now);
   end

   // R7: no strobe, no change
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> ($stable(win_idx) && $stable(win_any)));

   // R5: empty result reports index zero
   a_r5_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !win_any |-> (win_idx == '0));

   // R6: flag follows presence of a qualifying line at the capture edge
   a_r6_any_flag: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (win_any == $past(|elig_now)));

   // R1: a reported winner qualified when it was captured
   a_r1_winner_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      win_any |-> elig_q[win_idx]);
endmodule

bind arb_top arb_top_chk #(.NUM_BANKS(NUM_BANKS), .PRIO_W(PRIO_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .capture  (capture),
   .sel_fast (sel_fast),
   .pend     (pend),
   .mask     (mask),
   .route    (route),
   .win_idx  (win_idx),
   .win_any  (win_any)
);

// File: tb/arb_top_tb.sv
module arb_top_tb;
   localparam int NB = 3;
   localparam int PW = 6;
   localparam int N  = NB * 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            capture = 1'b0;
   logic            sel_fast = 1'b0;
   logic [N-1:0]    pend = '0;
   logic [N-1:0]    mask = '0;
   logic [N-1:0]    route = '0;
   logic [N*PW-1:0] prio_flat = '0;
   logic [6:0]      win_idx;
   logic            win_any;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   arb_top #(.NUM_BANKS(NB), .PRIO_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .capture(capture), .sel_fast(sel_fast),
      .pend(pend), .mask(mask), .route(route), .prio_flat(prio_flat),
      .win_idx(win_idx), .win_any(win_any)
   );

   function automatic int get_prio(int k);
      return int'(prio_flat[k*PW +: PW]);
   endfunction

   // Linear scan straight from the requirements
   task automatic model(output int e_idx, output bit e_any);
      int best = 1000;
      e_idx = 0;
      e_any = 1'b0;
      for (int k = 0; k < N; k++) begin
         if (pend[k] && !mask[k] && (route[k] == sel_fast) && get_prio(k) <= best) begin
            best  = get_prio(k);
            e_idx = k;
            e_any = 1'b1;
         end
      end
   endtask

   task automatic check(string req, int e_idx, bit e_any);
      n_chk++;
      if (int'(win_idx) != e_idx || win_any != e_any) begin
         n_fail++;
         $display("FAIL %s: idx=%0d any=%0b expected idx=%0d any=%0b",
                  req, win_idx, win_any, e_idx, e_any);
      end
   endtask

   // Inputs are set before the call, at a falling edge
   task automatic strobe();
      capture = 1'b1;
      @(negedge clk);
      capture = 1'b0;
   endtask

   task automatic strobe_model(string req);
      int e_idx;
      bit e_any;
      model(e_idx, e_any);
      strobe();
      check(req, e_idx, e_any);
   endtask

   task automatic clear_all();
      pend = '0; mask = '0; route = '0; prio_flat = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset", 0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: nothing pending
      strobe();
      check("R5 empty", 0, 1'b0);

      // R4 / R1: every single line in both classes
      for (int c = 0; c < 2; c++) begin
         sel_fast = c[0];
         for (int k = 0; k < N; k++) begin
            clear_all();
            pend[k] = 1'b1;
            route[k] = c[0];
            prio_flat[k*PW +: PW] = PW'(k % 64);
            strobe();
            check("R4 single line", k, 1'b1);
            route[k] = ~c[0];
            strobe();
            check("R1 wrong class", 0, 1'b0);
            route[k] = c[0];
            mask[k] = 1'b1;
            strobe();
            check("R1 masked", 0, 1'b0);
         end
      end

      // R3: full tie, normal class
      clear_all();
      sel_fast = 1'b0;
      pend = '1;
      for (int k = 0; k < N; k++) prio_flat[k*PW +: PW] = 6'd7;
      strobe();
      check("R3 full tie", 95, 1'b1);
      mask[95] = 1'b1;
      strobe();
      check("R3 tie top masked", 94, 1'b1);

      // R3: tie across banks
      clear_all();
      pend = '1;
      for (int k = 0; k < N; k++) prio_flat[k*PW +: PW] = 6'd9;
      prio_flat[5*PW +: PW] = 6'd3;
      prio_flat[70*PW +: PW] = 6'd3;
      strobe();
      check("R3 cross bank tie", 70, 1'b1);

      // R2: unique best below the top index
      clear_all();
      pend = '1;
      for (int k = 0; k < N; k++) prio_flat[k*PW +: PW] = 6'd1;
      prio_flat[40*PW +: PW] = 6'd0;
      strobe();
      check("R2 lowest value wins", 40, 1'b1);

      // R9: upper priority bit matters
      clear_all();
      pend[10] = 1'b1; pend[60] = 1'b1;
      prio_flat[10*PW +: PW] = 6'd31;
      prio_flat[60*PW +: PW] = 6'd32;
      strobe();
      check("R9 bit five", 10, 1'b1);

      // R10: same lines, two classes
      clear_all();
      pend = '1;
      for (int k = 0; k < N; k++) prio_flat[k*PW +: PW] = 6'd20;
      route[33] = 1'b1; route[50] = 1'b1;
      prio_flat[33*PW +: PW] = 6'd2;
      prio_flat[12*PW +: PW] = 6'd4;
      sel_fast = 1'b1;
      strobe();
      check("R10 fast class", 33, 1'b1);
      sel_fast = 1'b0;
      strobe();
      check("R10 normal class", 12, 1'b1);

      // R7: inputs move without a strobe
      clear_all();
      pend = '1;
      strobe();
      check("R7 setup", 95, 1'b1);
      pend = '0;
      sel_fast = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 hold", 95, 1'b1);
      strobe();
      check("R7 new strobe", 0, 1'b0);

      // R2 / R3 / R6: random patterns with dense ties
      for (int it = 0; it < 400; it++) begin
         pend  = {$urandom, $urandom, $urandom};
         mask  = {$urandom, $urandom, $urandom};
         route = {$urandom, $urandom, $urandom};
         if (it % 5 == 0) mask = mask | {$urandom, $urandom, $urandom};
         if (it % 7 == 0) pend = pend & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
         for (int k = 0; k < N; k++)
            prio_flat[k*PW +: PW] = (it % 2 == 0) ? PW'($urandom % 4) : PW'($urandom);
         sel_fast = 1'b0;
         strobe_model("R2 R3 R6 random normal");
         sel_fast = 1'b1;
         strobe_model("R2 R3 R6 random fast");
      end

      // R8: reset in mid run
      clear_all();
      pend = '1;
      strobe();
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 mid run reset", 0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: idx=%0d any=%0b expected idx=0 any=0", win_idx, win_any);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule